// File: doc/BRIEF.md
# CRC-Checked Command Link with Echo-on-Error and Reply Replay

This block guards a byte-wide command link between a host and the core logic that carries out commands. Incoming packets are parsed and held in a local buffer while a CRC-16 is accumulated over them. Only when the trailing CRC matches is the payload handed to the core as a stream. A packet whose CRC does not match is never handed on. Instead the host receives an error reply whose payload is the data exactly as it arrived, so the host can see what the link did to it. The block then returns to listening, and every further corrupted copy gets its own echo until a clean copy arrives.

On the outbound side, each reply that the core produces is framed with a type code, a length and a CRC of its own. A copy of the most recent reply, normal or error, is kept. A "say again" packet from the host makes the block send that stored reply once more without involving the core. Two saturating counters report how many CRC failures and how many replays have occurred. A packet that stalls in mid-frame for too long is dropped, and the parser resynchronises on the next byte.

Top module: `crc_retx_link`

## Requirements
- R1: A frame is a type byte, a length byte, that many payload bytes, then a CRC-16 with the high byte first. The CRC uses polynomial 0x1021 with a start value of 0xFFFF, is processed MSB first, and covers the length and payload bytes. Type 0x01 is a data command and type 0x04 is "say again". Any other byte seen where a type is expected is dropped. A length of 0 or above MAX_PAY (32) abandons the frame.
- R2: A data command whose CRC matches delivers exactly its payload on the core command stream, with core_cmd_last on the final byte only. No command byte is offered before the final CRC byte has been accepted.
- R3: A frame whose CRC does not match produces a reply of type 0x03. The reply carries the received length and payload byte for byte, with a correct CRC of its own. Nothing is delivered to the core.
- R4: Each further corrupted copy gets another echo reply. The first copy that passes is delivered normally.
- R5: A reply streamed in by the core is sent as type 0x02, with a length equal to the number of bytes and its own CRC. host_tx_data holds steady while host_tx_valid is high and host_tx_ready is low.
- R6: A "say again" frame with a good CRC resends the most recent reply, normal or echo, unchanged. It is never delivered to the core.
- R7: A "say again" frame that arrives before any reply has been sent produces the frame 0x03, 0x00, followed by the CRC of the single byte 0x00.
- R8: If IDLE_LIMIT cycles pass with no byte accepted while a frame is only partly received, that frame is discarded. The next byte is then treated as a type byte.
- R9: crc_fail_count rises by one for each CRC failure and replay_count rises by one for each replay of a stored reply. Both stop at their all-ones value.
- R10: A core reply longer than MAX_PAY bytes is sent with only its first MAX_PAY bytes and a length of MAX_PAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rx_data | input | 8 | Byte from host |
| host_rx_valid | input | 1 | Host byte valid |
| host_rx_ready | output | 1 | Block can take a host byte |
| host_tx_data | output | 8 | Byte to host |
| host_tx_valid | output | 1 | Byte to host valid |
| host_tx_ready | input | 1 | Host takes the byte |
| core_cmd_data | output | 8 | Verified command payload byte |
| core_cmd_valid | output | 1 | Command byte valid |
| core_cmd_last | output | 1 | Final byte of the command payload |
| core_cmd_ready | input | 1 | Core takes the command byte |
| core_rsp_data | input | 8 | Reply payload byte from core |
| core_rsp_valid | input | 1 | Reply byte valid |
| core_rsp_last | input | 1 | Final reply byte |
| core_rsp_ready | output | 1 | Block takes the reply byte |
| crc_fail_count | output | CNT_W | Saturating count of CRC failures |
| replay_count | output | CNT_W | Saturating count of reply replays |

## Verification
The bench sends clean data commands of length 1, 32 and random sizes, which show that payload delivery is exact and that the last flag lands on the final byte. Copies corrupted in a payload byte or in a CRC byte separate the echo path from the forward path, and a clean copy after two bad ones shows that the retry loop recovers. "Say again" is sent before any reply, after a normal reply and after an echo, which shows which stored reply is replayed. Stray type bytes, a zero length, a stalled half frame, an oversized core reply and long runs of failures and replays exercise the resynchronisation, truncation and saturation rules. Random backpressure on both output streams runs throughout.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam logic [7:0] TY_DATA  = 8'h01;
    localparam logic [7:0] TY_REPLY = 8'h02;
    localparam logic [7:0] TY_ECHO  = 8'h03;
    localparam logic [7:0] TY_AGAIN = 8'h04;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [1:0] {EV_NONE, EV_BAD, EV_AGAIN} ev_kind_t;

    typedef enum logic [2:0] {
        RX_TYPE, RX_LEN, RX_PAY, RX_CHI, RX_CLO, RX_FWD, RX_HOLD
    } rx_st_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_FILL, TX_ECHO, TX_TYPE, TX_LEN, TX_PAY, TX_CHI, TX_CLO
    } tx_st_t;

    // one byte into the running CRC, most significant bit first
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/lnk_sat_counter.sv
module lnk_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R9: once at the top value the count never wraps
    a_r9_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == TOP |=> cnt_q == TOP);

    // R9: the count moves only upward, one step at a time
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != $past(cnt_q) |-> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/lnk_rx_frame.sv
module lnk_rx_frame
    import lnk_pkg::*;
#(
    parameter int MAX_PAY    = 32,
    parameter int IDLE_LIMIT = 65535,
    localparam int IDX_W     = $clog2(MAX_PAY),
    localparam int IW        = $clog2(IDLE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       cmd_data,
    output logic             cmd_valid,
    output logic             cmd_last,
    input  logic             cmd_ready,
    output ev_kind_t         ev_kind,
    output logic [7:0]       ev_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             ev_ack,
    output logic             crc_bad
);
    localparam logic [7:0]    MAX_B  = 8'(MAX_PAY);
    localparam logic [IW-1:0] IDLE_T = IW'(IDLE_LIMIT - 1);

    typedef struct packed {
        rx_st_t        st;
        logic [7:0]    ty;
        logic [7:0]    len;
        logic [7:0]    idx;
        logic [15:0]   crc;
        logic [7:0]    chi;
        logic [IW-1:0] idle;
        ev_kind_t      ev;
    } rx_reg_t;

    rx_reg_t    r_d, r_q;
    logic [7:0] buf_d [MAX_PAY];
    logic [7:0] buf_q [MAX_PAY];
    logic       fire;
    logic       mid_frame;

    always_comb begin
        r_d       = r_q;
        buf_d     = buf_q;
        crc_bad   = 1'b0;
        in_ready  = r_q.st inside {RX_TYPE, RX_LEN, RX_PAY, RX_CHI, RX_CLO};
        fire      = in_ready && in_valid;
        mid_frame = r_q.st inside {RX_LEN, RX_PAY, RX_CHI, RX_CLO};
        cmd_valid = (r_q.st == RX_FWD);
        cmd_data  = buf_q[r_q.idx[IDX_W-1:0]];
        cmd_last  = cmd_valid && (r_q.idx == r_q.len - 8'd1);

        unique case (r_q.st)
            RX_TYPE: if (fire && (in_data == TY_DATA || in_data == TY_AGAIN)) begin
                r_d.ty = in_data;
                r_d.st = RX_LEN;
            end
            RX_LEN: if (fire) begin
                if (in_data == 8'd0 || in_data > MAX_B) begin
                    r_d.st = RX_TYPE;
                end else begin
                    r_d.len = in_data;
                    r_d.crc = crc16_step(CRC_SEED, in_data);
                    r_d.idx = '0;
                    r_d.st  = RX_PAY;
                end
            end
            RX_PAY: if (fire) begin
                buf_d[r_q.idx[IDX_W-1:0]] = in_data;
                r_d.crc = crc16_step(r_q.crc, in_data);
                r_d.idx = r_q.idx + 8'd1;
                if (r_q.idx == r_q.len - 8'd1) r_d.st = RX_CHI;
            end
            RX_CHI: if (fire) begin
                r_d.chi = in_data;
                r_d.st  = RX_CLO;
            end
            RX_CLO: if (fire) begin
                if (r_q.crc == {r_q.chi, in_data}) begin
                    if (r_q.ty == TY_DATA) begin
                        r_d.idx = '0;
                        r_d.st  = RX_FWD;
                    end else begin
                        r_d.ev = EV_AGAIN;
                        r_d.st = RX_HOLD;
                    end
                end else begin
                    crc_bad = 1'b1;
                    r_d.ev  = EV_BAD;
                    r_d.st  = RX_HOLD;
                end
            end
            RX_FWD: if (cmd_ready) begin
                r_d.idx = r_q.idx + 8'd1;
                if (cmd_last) r_d.st = RX_TYPE;
            end
            RX_HOLD: if (ev_ack) begin
                r_d.ev = EV_NONE;
                r_d.st = RX_TYPE;
            end
            default: r_d.st = RX_TYPE;
        endcase

        // stalled partial frame is thrown away
        if (fire) begin
            r_d.idle = '0;
        end else if (mid_frame) begin
            if (r_q.idle == IDLE_T) begin
                r_d.idle = '0;
                r_d.st   = RX_TYPE;
            end else begin
                r_d.idle = r_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: RX_TYPE, ev: EV_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
        buf_q <= buf_d;
    end

    assign ev_kind = (r_q.st == RX_HOLD) ? r_q.ev : EV_NONE;
    assign ev_len  = r_q.len;
    assign rd_data = buf_q[rd_idx];

    // R2: payload appears only right after the closing CRC byte was taken
    a_r2_release_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(fire));

    // R2: an offered command byte stays put until the core takes it
    a_r2_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

endmodule

// File: rtl/lnk_tx_frame.sv
module lnk_tx_frame
    import lnk_pkg::*;
#(
    parameter int MAX_PAY = 32,
    localparam int IDX_W  = $clog2(MAX_PAY)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_valid,
    input  logic             rsp_last,
    output logic             rsp_ready,
    input  ev_kind_t         ev_kind,
    input  logic [7:0]       ev_len,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data,
    output logic             ev_ack,
    output logic             replay
);
    localparam logic [7:0] MAX_B = 8'(MAX_PAY);

    typedef struct packed {
        tx_st_t      st;
        logic [7:0]  ty;
        logic [7:0]  len;
        logic [7:0]  idx;
        logic [15:0] crc;
        logic        has;
    } tx_reg_t;

    tx_reg_t    t_d, t_q;
    logic [7:0] buf_d [MAX_PAY];
    logic [7:0] buf_q [MAX_PAY];
    logic       send;

    always_comb begin
        t_d       = t_q;
        buf_d     = buf_q;
        ev_ack    = 1'b0;
        replay    = 1'b0;
        rsp_ready = (t_q.st == TX_FILL);
        rd_idx    = t_q.idx[IDX_W-1:0];
        out_valid = t_q.st inside {TX_TYPE, TX_LEN, TX_PAY, TX_CHI, TX_CLO};
        send      = out_valid && out_ready;

        unique case (t_q.st)
            TX_TYPE: out_data = t_q.ty;
            TX_LEN:  out_data = t_q.len;
            TX_PAY:  out_data = buf_q[t_q.idx[IDX_W-1:0]];
            TX_CHI:  out_data = t_q.crc[15:8];
            TX_CLO:  out_data = t_q.crc[7:0];
            default: out_data = 8'h00;
        endcase

        unique case (t_q.st)
            TX_IDLE: begin
                if (ev_kind == EV_BAD) begin
                    t_d.ty  = TY_ECHO;
                    t_d.len = ev_len;
                    t_d.idx = '0;
                    t_d.st  = TX_ECHO;
                end else if (ev_kind == EV_AGAIN) begin
                    ev_ack = 1'b1;
                    t_d.st = TX_TYPE;
                    if (t_q.has) begin
                        replay = 1'b1;
                    end else begin
                        t_d.ty  = TY_ECHO;
                        t_d.len = 8'd0;
                        t_d.has = 1'b1;
                    end
                end else if (rsp_valid) begin
                    t_d.idx = '0;
                    t_d.st  = TX_FILL;
                end
            end
            TX_FILL: if (rsp_valid) begin
                if (t_q.idx < MAX_B) begin
                    buf_d[t_q.idx[IDX_W-1:0]] = rsp_data;
                    t_d.idx = t_q.idx + 8'd1;
                end
                if (rsp_last) begin
                    t_d.ty  = TY_REPLY;
                    t_d.len = (t_q.idx < MAX_B) ? t_q.idx + 8'd1 : MAX_B;
                    t_d.has = 1'b1;
                    t_d.st  = TX_TYPE;
                end
            end
            TX_ECHO: begin
                buf_d[t_q.idx[IDX_W-1:0]] = rd_data;
                t_d.idx = t_q.idx + 8'd1;
                if (t_q.idx == t_q.len - 8'd1) begin
                    ev_ack  = 1'b1;
                    t_d.has = 1'b1;
                    t_d.st  = TX_TYPE;
                end
            end
            TX_TYPE: if (send) begin
                t_d.crc = CRC_SEED;
                t_d.st  = TX_LEN;
            end
            TX_LEN: if (send) begin
                t_d.crc = crc16_step(t_q.crc, t_q.len);
                t_d.idx = '0;
                t_d.st  = (t_q.len == 8'd0) ? TX_CHI : TX_PAY;
            end
            TX_PAY: if (send) begin
                t_d.crc = crc16_step(t_q.crc, out_data);
                t_d.idx = t_q.idx + 8'd1;
                if (t_q.idx == t_q.len - 8'd1) t_d.st = TX_CHI;
            end
            TX_CHI: if (send) t_d.st = TX_CLO;
            TX_CLO: if (send) t_d.st = TX_IDLE;
            default: t_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{st: TX_IDLE, default: '0};
        end else begin
            t_q <= t_d;
        end
        buf_q <= buf_d;
    end

    // R5: a stalled output byte is held unchanged
    a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6: a replay starts a frame on the very next cycle
    a_r6_replay_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        replay |=> out_valid);

endmodule

// File: rtl/crc_retx_link.sv
module crc_retx_link
    import lnk_pkg::*;
#(
    parameter int MAX_PAY    = 32,
    parameter int IDLE_LIMIT = 65535,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       host_rx_data,
    input  logic             host_rx_valid,
    output logic             host_rx_ready,
    output logic [7:0]       host_tx_data,
    output logic             host_tx_valid,
    input  logic             host_tx_ready,
    output logic [7:0]       core_cmd_data,
    output logic             core_cmd_valid,
    output logic             core_cmd_last,
    input  logic             core_cmd_ready,
    input  logic [7:0]       core_rsp_data,
    input  logic             core_rsp_valid,
    input  logic             core_rsp_last,
    output logic             core_rsp_ready,
    output logic [CNT_W-1:0] crc_fail_count,
    output logic [CNT_W-1:0] replay_count
);
    localparam int IDX_W = $clog2(MAX_PAY);

    ev_kind_t         ev_kind;
    logic [7:0]       ev_len;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic             ev_ack;
    logic             crc_bad;
    logic             replay;

    lnk_rx_frame #(.MAX_PAY(MAX_PAY), .IDLE_LIMIT(IDLE_LIMIT)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (host_rx_data),
        .in_valid  (host_rx_valid),
        .in_ready  (host_rx_ready),
        .cmd_data  (core_cmd_data),
        .cmd_valid (core_cmd_valid),
        .cmd_last  (core_cmd_last),
        .cmd_ready (core_cmd_ready),
        .ev_kind   (ev_kind),
        .ev_len    (ev_len),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .ev_ack    (ev_ack),
        .crc_bad   (crc_bad)
    );

    lnk_tx_frame #(.MAX_PAY(MAX_PAY)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_data  (host_tx_data),
        .out_valid (host_tx_valid),
        .out_ready (host_tx_ready),
        .rsp_data  (core_rsp_data),
        .rsp_valid (core_rsp_valid),
        .rsp_last  (core_rsp_last),
        .rsp_ready (core_rsp_ready),
        .ev_kind   (ev_kind),
        .ev_len    (ev_len),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .ev_ack    (ev_ack),
        .replay    (replay)
    );

    lnk_sat_counter #(.W(CNT_W)) u_fail_cnt (
        .clk (clk), .rst_n (rst_n), .inc (crc_bad), .cnt (crc_fail_count)
    );

    lnk_sat_counter #(.W(CNT_W)) u_replay_cnt (
        .clk (clk), .rst_n (rst_n), .inc (replay), .cnt (replay_count)
    );

    // R3: nothing reaches the core while an echo or replay is pending
    a_r3_no_forward_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_kind != EV_NONE |-> !core_cmd_valid);

endmodule

// File: tb/sim_crc_retx_link.sv
module sim_crc_retx_link;
    localparam int CW = 3;
    localparam int SAT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    host_rx_data = 8'h00;
    logic          host_rx_valid = 1'b0;
    logic          host_rx_ready;
    logic [7:0]    host_tx_data;
    logic          host_tx_valid;
    logic          host_tx_ready = 1'b1;
    logic [7:0]    core_cmd_data;
    logic          core_cmd_valid;
    logic          core_cmd_last;
    logic          core_cmd_ready = 1'b1;
    logic [7:0]    core_rsp_data = 8'h00;
    logic          core_rsp_valid = 1'b0;
    logic          core_rsp_last = 1'b0;
    logic          core_rsp_ready;
    logic [CW-1:0] crc_fail_count;
    logic [CW-1:0] replay_count;

    crc_retx_link #(.MAX_PAY(32), .IDLE_LIMIT(200), .CNT_W(CW)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    bit bp_on = 1'b0;
    byte unsigned txq[$], expq[$], cmdq[$], sent_pl[$], last_pl[$];
    bit           lastq[$];
    byte unsigned last_ty = 0;
    bit           have_last = 1'b0;
    int           exp_fail = 0, exp_replay = 0;

    function automatic logic [15:0] bcrc(input logic [15:0] c, input byte unsigned b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        host_tx_ready  = bp_on ? ($urandom % 4 != 0) : 1'b1;
        core_cmd_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (host_tx_valid && host_tx_ready) txq.push_back(host_tx_data);
        if (core_cmd_valid && core_cmd_ready) begin
            cmdq.push_back(core_cmd_data);
            lastq.push_back(core_cmd_last);
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_byte(input byte unsigned b);
        @(negedge clk);
        host_rx_valid = 1'b1; host_rx_data = b;
        while (!host_rx_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic host_gap();
        @(negedge clk); host_rx_valid = 1'b0;
    endtask

    // corrupt: -1 none, 0..n-1 payload byte, n or n+1 CRC byte
    task automatic host_send(input byte unsigned ty, input byte unsigned pl[$], input int corrupt);
        logic [15:0] c;
        byte unsigned fr[$];
        c = bcrc(16'hFFFF, byte'(pl.size()));
        foreach (pl[i]) c = bcrc(c, pl[i]);
        fr.push_back(ty); fr.push_back(byte'(pl.size()));
        foreach (pl[i]) fr.push_back(pl[i]);
        fr.push_back(c[15:8]); fr.push_back(c[7:0]);
        if (corrupt >= 0) fr[corrupt + 2] = fr[corrupt + 2] ^ (8'h01 << ($urandom % 8));
        sent_pl = {};
        for (int i = 0; i < pl.size(); i++) sent_pl.push_back(fr[i + 2]);
        foreach (fr[i]) put_byte(fr[i]);
        host_gap();
    endtask

    task automatic core_send(input byte unsigned pl[$]);
        for (int i = 0; i < pl.size(); i++) begin
            @(negedge clk);
            core_rsp_valid = 1'b1; core_rsp_data = pl[i]; core_rsp_last = (i == pl.size() - 1);
            while (!core_rsp_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk); core_rsp_valid = 1'b0; core_rsp_last = 1'b0;
    endtask

    task automatic expect_frame(input byte unsigned ty, input byte unsigned pl[$]);
        logic [15:0] c;
        c = bcrc(16'hFFFF, byte'(pl.size()));
        foreach (pl[i]) c = bcrc(c, pl[i]);
        expq.push_back(ty); expq.push_back(byte'(pl.size()));
        foreach (pl[i]) expq.push_back(pl[i]);
        expq.push_back(c[15:8]); expq.push_back(c[7:0]);
        last_ty = ty; last_pl = pl; have_last = 1'b1;
    endtask

    task automatic check_tx(input string req);
        int wait_n = 0;
        while (txq.size() < expq.size() && wait_n < 4000) begin @(negedge clk); wait_n++; end
        repeat (40) @(negedge clk);
        checks++;
        if (txq.size() != expq.size()) begin
            fails++;
            $display("FAIL %s: actual %0d host bytes expected %0d", req, txq.size(), expq.size());
        end else begin
            foreach (expq[i]) if (txq[i] != expq[i]) begin
                fails++;
                $display("FAIL %s: byte %0d actual %02h expected %02h", req, i, txq[i], expq[i]);
                break;
            end
        end
        txq = {}; expq = {};
    endtask

    task automatic check_cmd(input string req, input byte unsigned pl[$]);
        int wait_n = 0;
        bit bad = 1'b0;
        while (cmdq.size() < pl.size() && wait_n < 4000) begin @(negedge clk); wait_n++; end
        repeat (20) @(negedge clk);
        checks++;
        if (cmdq.size() != pl.size()) begin
            bad = 1'b1;
            $display("FAIL %s: actual %0d command bytes expected %0d", req, cmdq.size(), pl.size());
        end else begin
            foreach (pl[i]) if (cmdq[i] != pl[i] || lastq[i] != (i == pl.size() - 1)) begin
                bad = 1'b1;
                $display("FAIL %s: cmd byte %0d actual %02h/%0d expected %02h/%0d",
                         req, i, cmdq[i], lastq[i], pl[i], (i == pl.size() - 1));
                break;
            end
        end
        if (bad) fails++;
        cmdq = {}; lastq = {};
    endtask

    function automatic void rand_pl(output byte unsigned q[$], input int n);
        q = {};
        for (int i = 0; i < n; i++) q.push_back(byte'($urandom));
    endfunction

    task automatic say_again(input string req);
        byte unsigned one[$] = '{8'h5A};
        byte unsigned pl_copy[$];
        host_send(8'h04, one, -1);
        if (have_last) begin
            pl_copy = last_pl;
            expect_frame(last_ty, pl_copy);
            exp_replay++;
        end else begin
            pl_copy = {};
            expect_frame(8'h03, pl_copy);
        end
        check_tx(req);
    endtask

    initial begin
        byte unsigned p[$], z[$];
        int n, act;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        // reset state
        check_val("R2 reset cmd_valid", core_cmd_valid, 0);
        check_val("R5 reset tx_valid", host_tx_valid, 0);
        check_val("R9 reset fail count", crc_fail_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 ready after reset", host_rx_ready, 1);

        // R7 say again with no stored reply
        say_again("R7 empty say-again");
        check_val("R9 no replay counted", replay_count, 0);

        // R2 clean commands, length 1 and 32
        rand_pl(p, 1);  host_send(8'h01, p, -1); check_cmd("R2 len 1", p);
        rand_pl(p, 32); host_send(8'h01, p, -1); check_cmd("R2 len 32", p);
        check_tx("R2 no host output for good command");

        // R5 normal reply, R6 replay of it
        rand_pl(p, 9); core_send(p); expect_frame(8'h02, p); check_tx("R5 reply frame");
        say_again("R6 replay of normal reply");
        check_cmd("R6 say-again not forwarded", z);
        check_val("R9 replay count", replay_count, exp_replay);

        // R3 / R4 two corrupted copies then a clean one
        rand_pl(p, 12);
        host_send(8'h01, p, 4);  expect_frame(8'h03, sent_pl); exp_fail++;
        check_tx("R3 echo of corrupted payload");
        check_cmd("R3 bad copy not forwarded", z);
        host_send(8'h01, p, 13); expect_frame(8'h03, sent_pl); exp_fail++;
        check_tx("R4 second echo, CRC byte hit");
        host_send(8'h01, p, -1); check_cmd("R4 clean copy forwarded", p);
        check_val("R9 fail count", crc_fail_count, exp_fail);
        say_again("R6 replay of echo reply");

        // R1 stray type bytes, zero length
        put_byte(8'h07); put_byte(8'h00); put_byte(8'h02); host_gap();
        rand_pl(p, 5); host_send(8'h01, p, -1); check_cmd("R1 stray type bytes dropped", p);
        put_byte(8'h01); put_byte(8'h00); host_gap();
        rand_pl(p, 3); host_send(8'h01, p, -1); check_cmd("R1 zero length abandoned", p);
        put_byte(8'h01); put_byte(8'd33); host_gap();
        rand_pl(p, 4); host_send(8'h01, p, -1); check_cmd("R1 oversize length abandoned", p);

        // R8 stalled half frame
        put_byte(8'h01); put_byte(8'd6); put_byte(8'hAA); host_gap();
        repeat (230) @(negedge clk);
        rand_pl(p, 6); host_send(8'h01, p, -1); check_cmd("R8 stall timeout resync", p);
        check_tx("R8 no host output after stall");

        // R10 oversize core reply
        rand_pl(p, 40); core_send(p);
        z = p[0:31]; expect_frame(8'h02, z); check_tx("R10 truncated reply");
        z = {};

        // random mix with backpressure
        bp_on = 1'b1;
        for (int it = 0; it < 30; it++) begin
            int act_k = $urandom % 5;
            n = 1 + $urandom % 32;
            rand_pl(p, n);
            if (act_k <= 1) begin
                if ($urandom % 3 == 0) begin
                    host_send(8'h01, p, $urandom % (n + 2));
                    expect_frame(8'h03, sent_pl); exp_fail++;
                    check_tx("R3 random echo");
                    check_cmd("R3 random no forward", z);
                end else begin
                    host_send(8'h01, p, -1); check_cmd("R2 random command", p);
                end
            end else if (act_k == 2) begin
                core_send(p); expect_frame(8'h02, p); check_tx("R5 random reply");
            end else if (act_k == 3) begin
                say_again("R6 random replay");
            end else begin
                host_send(8'h04, p, $urandom % (n + 2));
                expect_frame(8'h03, sent_pl); exp_fail++;
                check_tx("R3 corrupted say-again echoed");
            end
        end
        bp_on = 1'b0;

        // R9 saturation
        while (exp_fail < SAT + 3) begin
            rand_pl(p, 2); host_send(8'h01, p, 0);
            expect_frame(8'h03, sent_pl); exp_fail++; check_tx("R9 echo during saturation");
        end
        check_val("R9 fail count saturated", crc_fail_count, SAT);
        while (exp_replay < SAT + 3) say_again("R9 replay during saturation");
        act = replay_count;
        check_val("R9 replay count saturated", act, SAT);

        summary();
        $finish;
    end
endmodule